// File: doc/BRIEF.md
# Serial Control Register Port with Peak-Level Capture

This block is the control-side slave of an audio converter. A host drives a four-wire serial link: an active-low latch that frames each transfer, a serial clock, a data line into the block and a data line out of it. Each 16-bit frame either writes one 10-bit control register or asks for one register's contents. The control registers drive a flat parallel bus that the rest of the chip decodes. The serial clock has no phase relation to the system clock, so all three host inputs pass through two-flop synchronisers, and the block works only on edges seen in the system clock domain.

Two read-only registers report input signal level, one per capture channel. Each one takes the magnitude of every valid sample and keeps the loudest level seen. The level is coded as 0 to 63 dB below full scale in 1 dB steps. A completed read of one of these registers returns the held value and re-arms the register for a new measurement. Capture runs only while the peak-enable control bit is set.

Top module: `codec_ctrl_port`

## Requirements
- R1: A frame carries the address in bits 15:12, the direction in bit 11 (0 = write, 1 = read), a reserved bit in bit 10 and the value in bits 9:0, sent MSB first. A write to address 0 to 10 updates that register's 10-bit slice of `cfg_o` (register n at bits 10n+9:10n) once the latch rises.
- R2: After reset, registers 2 to 7 hold 0x3FF and every other control register holds 0. Both peak registers hold code 63.
- R3: A read frame loads a 16-bit response {address, 1, 0, value} that is shifted out on `ctl_sdo` during the next frame, MSB first. The first bit is valid after the latch falls, and each later bit follows a falling serial clock edge. Any frame that is not an accepted read leaves a response of zero for the next frame.
- R4: A frame with bit 10 set is ignored. It writes nothing, clears nothing and yields a zero response.
- R5: A write to address 11 or above changes no control register and does not alter either peak register.
- R6: A frame in which the latch rises after any bit count other than 16 is discarded.
- R7: A peak register is read as code in bits 9:4 with bits 3:0 zero. The code for a sample is the number of steps k in 1..63 for which |sample| is below full scale scaled by 10^(-k/20). So a full-scale sample of either sign gives 0, a half-scale sample gives 6, 0.85 of full scale gives 1, and zero gives 63. Peak register for channel 0 is address 11, channel 1 is address 12.
- R8: While it is not being cleared, a peak register keeps the smallest code (the loudest level) seen since its last clear.
- R9: When the latch rises after a complete read frame of a peak register, that register returns to 63.
- R10: Samples are captured only while bit 0 of register 10 is 1. Otherwise the peak registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_latch_n | input | 1 | Frame latch, low during a transfer |
| ctl_sck | input | 1 | Serial clock from the host |
| ctl_sdi | input | 1 | Serial data into the block, sampled on the rising serial clock |
| ctl_sdo | output | 1 | Serial response data, changing after a falling serial clock |
| smp_vld | input | N_PEAK | Per-channel sample strobe |
| smp_data | input | N_PEAK*SAMPLE_W | Two's-complement samples, channel 0 in the low slice |
| cfg_o | output | N_CTRL*10 | All control registers, register n at bits 10n+9:10n |

## Verification
The bench builds the block with its default parameters: eleven control registers, two capture channels and 24-bit samples. With these values the full-scale, negative full-scale, half-scale and silent samples land on exact known codes, and every address class can be reached: writable, read-only peak and unused. The serial clock runs ten system clocks per half period, which leaves room for the synchroniser delay when the response bits are sampled. The stimulus mixes accepted frames with reserved-bit frames, short frames and writes to read-only addresses. This shows that each one reaches the register bank only when it should.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 10;
  localparam int CODE_W  = 6;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              rsvd;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
  parameter int        W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ctrl_spi_frame.sv
module ctrl_spi_frame
  import codec_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sck_s,
  input  logic               sdi_s,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               frm_done,
  output logic               frm_ok,
  output logic [FRAME_W-1:0] frm_word,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W) + 2;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic               cs_prev_q, sck_prev_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic               done_q, done_d;
  logic               ok_q, ok_d;

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = cs_prev_q & ~cs_n_s;
  assign cs_rise  = ~cs_prev_q & cs_n_s;
  assign sck_rise = ~sck_prev_q & sck_s & ~cs_n_s;
  assign sck_fall = sck_prev_q & ~sck_s & ~cs_n_s;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    done_d = 1'b0;
    ok_d   = 1'b0;
    if (cs_fall) begin
      cnt_d = '0;
      rx_d  = '0;
      tx_d  = tx_word;
    end else if (cs_rise) begin
      done_d = 1'b1;
      ok_d   = (cnt_q == CNT_FULL);
    end else begin
      if (sck_rise) begin
        rx_d = {rx_q[FRAME_W-2:0], sdi_s};
        if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
    end else begin
      cs_prev_q  <= cs_n_s;
      sck_prev_q <= sck_s;
      cnt_q      <= cnt_d;
      rx_q       <= rx_d;
      tx_q       <= tx_d;
      done_q     <= done_d;
      ok_q       <= ok_d;
    end
  end

  assign frm_done = done_q;
  assign frm_ok   = ok_q;
  assign frm_word = rx_q;
  assign sdo      = tx_q[FRAME_W-1];
endmodule

// File: rtl/ctrl_peak_track.sv
module ctrl_peak_track
  import codec_ctrl_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                clr,
  input  logic                vld,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [CODE_W-1:0]   code
);
  localparam int N_STEP = CODE_MAX;
  // 10^(-1/20) as a 16-bit fraction
  localparam longint STEP_NUM = 58409;

  function automatic logic [SAMPLE_W-1:0] step_thr(input int k);
    longint t;
    t = (longint'(1) << (SAMPLE_W - 1)) - 1;
    for (int j = 0; j < k; j++) t = (t * STEP_NUM) >>> 16;
    return SAMPLE_W'(t);
  endfunction

  logic [SAMPLE_W-1:0] mag;
  logic [N_STEP-1:0]   below;
  logic [CODE_W-1:0]   smp_code;
  logic [CODE_W-1:0]   code_q, code_d;

  assign mag = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;

  for (genvar k = 1; k <= N_STEP; k++) begin : g_step
    localparam logic [SAMPLE_W-1:0] THR = step_thr(k);
    assign below[k-1] = (mag < THR);
  end

  always_comb begin
    smp_code = '0;
    for (int i = 0; i < N_STEP; i++) smp_code = smp_code + CODE_W'(below[i]);
  end

  always_comb begin
    code_d = code_q;
    if (clr)
      code_d = CODE_W'(CODE_MAX);
    else if (en && vld && (smp_code < code_q))
      code_d = smp_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= CODE_W'(CODE_MAX);
    else        code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port
  import codec_ctrl_pkg::*;
#(
  parameter int N_CTRL    = 11,
  parameter int N_PEAK    = 2,
  parameter int SAMPLE_W  = 24,
  parameter int EN_ADDR   = 10,
  parameter int EN_BIT    = 0,
  parameter int VOL_FIRST = 2,
  parameter int VOL_LAST  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_latch_n,
  input  logic                         ctl_sck,
  input  logic                         ctl_sdi,
  output logic                         ctl_sdo,
  input  logic [N_PEAK-1:0]            smp_vld,
  input  logic [N_PEAK*SAMPLE_W-1:0]   smp_data,
  output logic [N_CTRL*DATA_W-1:0]     cfg_o
);
  localparam int PEAK_BASE = N_CTRL;
  localparam int PAD_W     = DATA_W - CODE_W;

  function automatic logic [DATA_W-1:0] ctrl_default(input int idx);
    return (idx >= VOL_FIRST && idx <= VOL_LAST) ? '1 : '0;
  endfunction

  // synchronised host pins: {latch, sck, sdi}
  logic [2:0] pins_s;
  ctrl_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ctl_latch_n, ctl_sck, ctl_sdi}),
    .q    (pins_s)
  );

  logic               frm_done, frm_ok;
  logic [FRAME_W-1:0] frm_word;
  logic [FRAME_W-1:0] resp_q, resp_d;
  frame_t             frm;

  ctrl_spi_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (pins_s[2]),
    .sck_s   (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .tx_word (resp_q),
    .frm_done(frm_done),
    .frm_ok  (frm_ok),
    .frm_word(frm_word),
    .sdo     (ctl_sdo)
  );

  assign frm = frame_t'(frm_word);

  logic accept, wr_acc, rd_acc;
  assign accept = frm_done & frm_ok & ~frm.rsvd;
  assign wr_acc = accept & ~frm.rd;
  assign rd_acc = accept & frm.rd;

  // control register bank
  logic [DATA_W-1:0] ctrl_q [N_CTRL];
  logic [DATA_W-1:0] ctrl_d [N_CTRL];

  for (genvar r = 0; r < N_CTRL; r++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(r);
    localparam logic [DATA_W-1:0] DFLT    = ctrl_default(r);
    always_comb begin
      ctrl_d[r] = ctrl_q[r];
      if (wr_acc && frm.addr == MY_ADDR) ctrl_d[r] = frm.data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[r] <= DFLT;
      else        ctrl_q[r] <= ctrl_d[r];
    end
    assign cfg_o[r*DATA_W +: DATA_W] = ctrl_q[r];
  end

  // peak capture channels
  logic                     peak_en;
  logic [N_PEAK-1:0]        peak_clr;
  logic [N_PEAK*CODE_W-1:0] peak_codes;

  assign peak_en = ctrl_q[EN_ADDR][EN_BIT];

  for (genvar c = 0; c < N_PEAK; c++) begin : g_peak
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PEAK_BASE + c);
    assign peak_clr[c] = rd_acc & (frm.addr == MY_ADDR);
    ctrl_peak_track #(.SAMPLE_W(SAMPLE_W)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (peak_en),
      .clr   (peak_clr[c]),
      .vld   (smp_vld[c]),
      .sample(smp_data[c*SAMPLE_W +: SAMPLE_W]),
      .code  (peak_codes[c*CODE_W +: CODE_W])
    );
  end

  // read value selection
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int r = 0; r < N_CTRL; r++)
      if (frm.addr == ADDR_W'(r)) rd_val = ctrl_q[r];
    for (int c = 0; c < N_PEAK; c++)
      if (frm.addr == ADDR_W'(PEAK_BASE + c))
        rd_val = {peak_codes[c*CODE_W +: CODE_W], {PAD_W{1'b0}}};
  end

  always_comb begin
    resp_d = resp_q;
    if (frm_done) resp_d = rd_acc ? {frm.addr, 1'b1, 1'b0, rd_val} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= resp_d;
  end
endmodule

// File: rtl/codec_ctrl_port_chk.sv
module codec_ctrl_port_chk #(
  parameter int N_CTRL = 11,
  parameter int N_PEAK = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frm_done,
  input logic                    frm_ok,
  input logic [3:0]              frm_addr,
  input logic                    frm_rsvd,
  input logic [N_CTRL*10-1:0]    cfg_o,
  input logic [N_PEAK*6-1:0]     peak_codes,
  input logic [N_PEAK-1:0]       peak_clr,
  input logic                    peak_en
);
  // R1: the bank only moves when a frame has just ended
  p_cfg_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |=> $stable(cfg_o));

  // R4: reserved-bit frames never reach the bank
  p_rsvd_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_rsvd) |=> $stable(cfg_o));

  // R5: read-only and unused addresses never reach the bank
  p_ro_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && 32'(frm_addr) >= N_CTRL) |=> $stable(cfg_o));

  // R6: incomplete frames never reach the bank
  p_short_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !frm_ok) |=> $stable(cfg_o));

  for (genvar c = 0; c < N_PEAK; c++) begin : g_chk
    // R8: held level only gets louder between clears
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !peak_clr[c] |=> peak_codes[c*6 +: 6] <= $past(peak_codes[c*6 +: 6]));
    // R9: a completed read re-arms the register
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      peak_clr[c] |=> peak_codes[c*6 +: 6] == 6'd63);
    // R10: no capture while disabled
    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!peak_en && !peak_clr[c]) |=> $stable(peak_codes[c*6 +: 6]));
  end
endmodule

bind codec_ctrl_port codec_ctrl_port_chk #(.N_CTRL(N_CTRL), .N_PEAK(N_PEAK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_done  (frm_done),
  .frm_ok    (frm_ok),
  .frm_addr  (frm_word[15:12]),
  .frm_rsvd  (frm_word[10]),
  .cfg_o     (cfg_o),
  .peak_codes(peak_codes),
  .peak_clr  (peak_clr),
  .peak_en   (peak_en)
);

// File: tb/tb_codec_ctrl_port.sv
`timescale 1ns/1ps
module tb_codec_ctrl_port;
  localparam int N_CTRL = 11;
  localparam int N_PEAK = 2;
  localparam int SW     = 24;
  localparam int HALF   = 100;
  localparam logic [SW-1:0] FS_POS = 24'h7FFFFF;
  localparam logic [SW-1:0] FS_NEG = 24'h800000;
  localparam logic [SW-1:0] HALF_S = 24'd4194304;
  localparam logic [SW-1:0] S085   = 24'd7130316;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [N_PEAK-1:0] vld = '0;
  logic [N_PEAK*SW-1:0] sdata = '0;
  logic [N_CTRL*10-1:0] cfg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  codec_ctrl_port dut (
    .clk(clk), .rst_n(rst_n), .ctl_latch_n(latch_n), .ctl_sck(sck),
    .ctl_sdi(sdi), .ctl_sdo(sdo), .smp_vld(vld), .smp_data(sdata), .cfg_o(cfg)
  );

  // {frame, register index to inspect, expected value}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {16'h0155, 4'd0,  10'h155},  // R1 write reg0
    {16'h12AA, 4'd1,  10'h2AA},  // R1 write reg1
    {16'hA001, 4'd10, 10'h001},  // R1 write enable reg
    {16'h17FF, 4'd1,  10'h2AA},  // R4 reserved bit set, ignored
    {16'hC0FF, 4'd10, 10'h001},  // R5 write to peak address ignored
    {16'h7000, 4'd7,  10'h000},  // R1 write reg7 to zero
    {16'h3123, 4'd3,  10'h123},  // R1 write reg3
    {16'h3800, 4'd3,  10'h123}   // R3 read leaves reg3 alone
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] rx);
    rx = '0;
    latch_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15-i];
      #HALF;
      rx = {rx[14:0], sdo};
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
    #HALF;
    latch_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] resp);
    logic [15:0] dummy;
    xfer({a, 1'b1, 1'b0, 10'h0}, 16, dummy);
    xfer(16'h0400, 16, resp);
  endtask

  task automatic push(input int ch, input logic [SW-1:0] v);
    sdata[ch*SW +: SW] = v;
    vld[ch] = 1'b1;
    #10;
    vld[ch] = 1'b0;
    #20;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [N_CTRL*10-1:0] snap;
    #53;
    rst_n = 1'b1;
    #100;

    // R2 reset defaults
    for (int i = 0; i < N_CTRL; i++)
      check("R2 default", cfg[i*10 +: 10], (i >= 2 && i <= 7) ? 10'h3FF : 10'h0);
    rd_reg(4'd11, r);
    check("R2 peak0 reset / R7 field", r, 16'hBBF0);
    rd_reg(4'd2, r);
    check("R3 read default reg2", r, 16'h2BFF);

    // R10 capture gated while enable bit is clear
    push(0, FS_POS);
    rd_reg(4'd11, r);
    check("R10 disabled capture", r, 16'hBBF0);

    // table of frames
    for (int v = 0; v < NV; v++) begin
      logic [15:0] f;
      f = VEC[v][29:14];
      xfer(f, 16, r);
      check("R1/R4/R5 table", cfg[VEC[v][13:10]*10 +: 10], VEC[v][9:0]);
    end

    // R3 read of a written register, MSB first
    rd_reg(4'd3, r);
    check("R3 read reg3", r, 16'h3923);

    // R7 codes and R8 hold
    push(0, HALF_S);
    rd_reg(4'd11, r);
    check("R7 half scale code 6", r, 16'hB860);
    push(0, S085);
    push(0, 24'd0);
    push(0, HALF_S);
    rd_reg(4'd11, r);
    check("R8 hold loudest, code 1", r, 16'hB810);
    rd_reg(4'd11, r);
    check("R9 cleared after read", r, 16'hBBF0);
    push(1, FS_NEG);
    rd_reg(4'd12, r);
    check("R7 negative full scale code 0", r, 16'hC800);
    push(0, 24'd0);
    rd_reg(4'd11, r);
    check("R7 zero code 63", r, 16'hBBF0);

    // R5 write to peak address leaves peak alone
    push(0, FS_POS);
    snap = cfg;
    xfer(16'hB3FF, 16, r);
    check("R5 bank unchanged", cfg, snap);
    rd_reg(4'd11, r);
    check("R5 peak not touched", r, 16'hB800);

    // R4 reserved-bit read clears nothing and answers zero
    push(1, HALF_S);
    xfer(16'hCC00, 16, r);
    xfer(16'h0400, 16, r);
    check("R4 reserved read zero response", r, 16'h0000);
    rd_reg(4'd12, r);
    check("R4 peak1 not cleared", r, 16'hC860);

    // R6 short frame discarded
    xfer(16'h0000, 12, r);
    check("R6 short frame reg0", cfg[9:0], 10'h155);
    xfer(16'h0800, 12, r);
    xfer(16'h0400, 16, r);
    check("R6 short read no response", r, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule